// File: doc/BRIEF.md
# MAC Pause Flow Control Unit

This block manages IEEE 802.3 PAUSE flow control for a MAC whose link partner is a switch fabric. A 32-bit control word holds the pause time, a receive-decode enable, a pass-flag control and a read-only busy indication. In full duplex, a request makes the unit emit the header and payload fields of a PAUSE control frame, one byte per accepted cycle, carrying the programmed pause time. In half duplex, the same request becomes a back-pressure level.

On the receive side, the unit watches a byte-wide frame stream. It recognises PAUSE frames and holds off the transmitter for the decoded quanta multiplied by one slot time (64 byte clocks). It also produces a per-frame status strobe with a packet-filter flag. Frames are never dropped: the flag only tells the application that a valid pause frame arrived. CRC handling, address filtering and threshold logic sit outside this unit.

Top module: `mac_pause_ctrl`

## Requirements
- R1: After synchronous reset, reg_rdata reads 0, and pf_valid, back_pressure, tx_hold and rx_status_valid are all 0.
- R2: The control word has pause time in bits 31:16, pass flag in bit 2, decode enable in bit 1 and busy in bit 0. A write updates bits 31:16, 2 and 1 in the next cycle. Bits 15:3 always read 0, and bit 0 is never written.
- R3: A write issued while busy reads 1 is ignored, and the control word keeps its earlier value.
- R4: In full duplex, a request starts an 18-byte sequence in the next cycle. The sequence is: destination 01 80 C2 00 00 01, the SRC_MAC parameter (high byte first), type 88 08, opcode 00 01, then the pause time high byte and low byte. The unit advances one byte per cycle in which pf_ready is 1, holds pf_byte while pf_ready is 0, and raises pf_last on the final byte.
- R5: In full duplex, busy reads 1 from the cycle after an accepted request until the last byte has been accepted. It reads 0 in the following cycle.
- R6: In half duplex, back_pressure follows request AND decode enable AND transmitter enabled, one cycle later, and busy reads the same value.
- R7: While tx_enabled is 0, no frame sequence starts and back_pressure stays 0.
- R8: In full duplex with decode enable set, a valid PAUSE frame makes tx_hold rise in the cycle after its final byte. tx_hold stays high for exactly quanta × 64 cycles. A valid frame has the destination, type 88 08 and opcode 00 01 at bytes 0–5, 12–13 and 14–15, with the big-endian quanta at bytes 16–17, and is at least 18 bytes long.
- R9: No pause is decoded when decode enable is 0, in half duplex, or when the destination, type or opcode does not match.
- R10: rx_status_valid pulses for one cycle after the final byte of every frame. rx_status_filter is 1 only for a decoded PAUSE frame with the pass flag set and promiscuous mode off.
- R11: A valid PAUSE frame that arrives during a running pause restarts the count from its own quanta, and a quanta of 0 ends the pause at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read value |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_enabled | input | 1 | Transmitter enabled |
| promisc | input | 1 | Promiscuous filtering mode active |
| pause_req | input | 1 | Request pause frame or back pressure |
| pf_ready | input | 1 | Transmit path accepts the current byte |
| pf_valid | output | 1 | Pause frame byte valid |
| pf_byte | output | 8 | Pause frame byte |
| pf_last | output | 1 | Final pause frame byte |
| back_pressure | output | 1 | Half-duplex back pressure |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a receive frame |
| rx_eof | input | 1 | Final byte of a receive frame |
| rx_byte | input | 8 | Receive byte |
| rx_status_valid | output | 1 | Per-frame status strobe |
| rx_status_filter | output | 1 | Packet-filter flag in receive status |
| tx_hold | output | 1 | Transmitter hold-off |

## Verification
A wrong byte index in the frame sequencer shows up on pf_byte at the first misplaced field. The wrong value, or a missing pf_last, is visible within 18 accepted cycles of the request, and busy then stays high too long or drops too early. A corrupted match flag or quanta capture in the receive decoder shows up one cycle after the frame's final byte, as a wrong filter flag on the status strobe or a missing or spurious tx_hold rise. A faulty countdown only appears as a hold length that differs from quanta × 64, so the bench measures whole hold windows, including reloads and a zero quanta.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int REG_W     = 32;
  localparam int PT_W      = 16;
  localparam int FRAME_LEN = 18;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);
  localparam logic [47:0] PAUSE_DA   = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_ETYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OP   = 16'h0001;

  // header check for one receive byte at a given position
  function automatic logic hdr_byte_ok(input logic [IDX_W-1:0] idx, input logic [7:0] b);
    logic ok;
    ok = 1'b1;
    if (idx < IDX_W'(6))
      ok = (b == PAUSE_DA[8*(5-int'(idx)) +: 8]);
    else if (idx == IDX_W'(12))
      ok = (b == CTRL_ETYPE[15:8]);
    else if (idx == IDX_W'(13))
      ok = (b == CTRL_ETYPE[7:0]);
    else if (idx == IDX_W'(14))
      ok = (b == PAUSE_OP[15:8]);
    else if (idx == IDX_W'(15))
      ok = (b == PAUSE_OP[7:0]);
    return ok;
  endfunction
endpackage

// File: rtl/pause_cfg_reg.sv
module pause_cfg_reg
  import pause_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy_i,
  output logic [PT_W-1:0]  pause_time,
  output logic             fcen,
  output logic             pass,
  output logic [REG_W-1:0] rdata
);
  localparam int RSV_W = REG_W - PT_W - 3;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[REG_W-PT_W-1:3], wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_time <= '0;
      fcen       <= 1'b0;
      pass       <= 1'b0;
    end else if (wr_en && !busy_i) begin
      pause_time <= wdata[REG_W-1 -: PT_W];
      pass       <= wdata[2];
      fcen       <= wdata[1];
    end
  end

  assign rdata = {pause_time, {RSV_W{1'b0}}, pass, fcen, busy_i};
endmodule

// File: rtl/pause_tx_seq.sv
module pause_tx_seq
  import pause_pkg::*;
#(
  parameter logic [47:0] SRC_MAC = 48'h0200_0000_000A
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [PT_W-1:0] pause_time,
  input  logic            ready,
  output logic            valid,
  output logic [7:0]      byte_o,
  output logic            last,
  output logic            active
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [IDX_W-1:0] idx;
  logic [PT_W-1:0]  quanta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      idx      <= '0;
      quanta_q <= '0;
    end else if (start && !active) begin
      active   <= 1'b1;
      idx      <= '0;
      quanta_q <= pause_time;
    end else if (active && ready) begin
      if (idx == LAST_IDX) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    byte_o = 8'h00;
    if (idx < IDX_W'(6))
      byte_o = PAUSE_DA[8*(5-int'(idx)) +: 8];
    else if (idx < IDX_W'(12))
      byte_o = SRC_MAC[8*(11-int'(idx)) +: 8];
    else begin
      case (idx)
        IDX_W'(12): byte_o = CTRL_ETYPE[15:8];
        IDX_W'(13): byte_o = CTRL_ETYPE[7:0];
        IDX_W'(14): byte_o = PAUSE_OP[15:8];
        IDX_W'(15): byte_o = PAUSE_OP[7:0];
        IDX_W'(16): byte_o = quanta_q[15:8];
        default:    byte_o = quanta_q[7:0];
      endcase
    end
  end

  assign valid = active;
  assign last  = active && (idx == LAST_IDX);
endmodule

// File: rtl/pause_rx_decode.sv
module pause_rx_decode
  import pause_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_valid,
  input  logic            rx_sof,
  input  logic            rx_eof,
  input  logic [7:0]      rx_byte,
  input  logic            decode_en,
  input  logic            pass,
  input  logic            promisc,
  output logic            load_o,
  output logic [PT_W-1:0] quanta_o,
  output logic            status_valid,
  output logic            status_filter
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] Q_HI    = IDX_W'(FRAME_LEN - 2);
  localparam logic [IDX_W-1:0] Q_LO    = IDX_W'(FRAME_LEN - 1);

  logic [IDX_W-1:0] cnt;
  logic             hdr_ok;
  logic [7:0]       q_hi;
  logic [PT_W-1:0]  q_full;

  logic [IDX_W-1:0] idx_now;
  logic             ok_now;
  logic             pause_ok;

  always_comb begin
    idx_now  = rx_sof ? '0 : cnt;
    ok_now   = (rx_sof ? 1'b1 : hdr_ok) && hdr_byte_ok(idx_now, rx_byte);
    quanta_o = (idx_now == Q_LO) ? {q_hi, rx_byte} : q_full;
    pause_ok = rx_valid && rx_eof && ok_now && (idx_now >= Q_LO) && decode_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt           <= '0;
      hdr_ok        <= 1'b0;
      q_hi          <= '0;
      q_full        <= '0;
      status_valid  <= 1'b0;
      status_filter <= 1'b0;
    end else begin
      status_valid  <= rx_valid && rx_eof;
      status_filter <= pause_ok && pass && !promisc;
      if (rx_valid) begin
        hdr_ok <= ok_now;
        if (idx_now != IDX_MAX) cnt <= idx_now + 1'b1;
        else                    cnt <= idx_now;
        if (idx_now == Q_HI) q_hi   <= rx_byte;
        if (idx_now == Q_LO) q_full <= {q_hi, rx_byte};
      end
    end
  end

  assign load_o = pause_ok;
endmodule

// File: rtl/pause_hold_timer.sv
module pause_hold_timer
  import pause_pkg::*;
#(
  parameter int SLOT_TICKS = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [PT_W-1:0] quanta,
  output logic            hold
);
  localparam int SLOT_W = $clog2(SLOT_TICKS);
  localparam int CNT_W  = PT_W + SLOT_W;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (load)
      count <= CNT_W'(quanta) * CNT_W'(SLOT_TICKS);
    else if (count != '0)
      count <= count - 1'b1;
  end

  assign hold = (count != '0);
endmodule

// File: rtl/mac_pause_ctrl.sv
module mac_pause_ctrl
  import pause_pkg::*;
#(
  parameter logic [47:0] SRC_MAC    = 48'h0200_0000_000A,
  parameter int          SLOT_TICKS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        full_duplex,
  input  logic        tx_enabled,
  input  logic        promisc,
  input  logic        pause_req,
  input  logic        pf_ready,
  output logic        pf_valid,
  output logic [7:0]  pf_byte,
  output logic        pf_last,
  output logic        back_pressure,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_byte,
  output logic        rx_status_valid,
  output logic        rx_status_filter,
  output logic        tx_hold
);
  logic [PT_W-1:0] pause_time;
  logic            fcen, pass, busy, tx_active, tx_start;
  logic            rx_load;
  logic [PT_W-1:0] rx_quanta;

  assign busy     = full_duplex ? tx_active : back_pressure;
  assign tx_start = pause_req && full_duplex && tx_enabled && !tx_active;

  always_ff @(posedge clk) begin
    if (rst) back_pressure <= 1'b0;
    else     back_pressure <= pause_req && fcen && tx_enabled && !full_duplex;
  end

  pause_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wdata(reg_wdata), .busy_i(busy),
    .pause_time(pause_time), .fcen(fcen), .pass(pass), .rdata(reg_rdata)
  );

  pause_tx_seq #(.SRC_MAC(SRC_MAC)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .pause_time(pause_time), .ready(pf_ready),
    .valid(pf_valid), .byte_o(pf_byte), .last(pf_last), .active(tx_active)
  );

  pause_rx_decode u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_byte(rx_byte), .decode_en(fcen && full_duplex), .pass(pass), .promisc(promisc),
    .load_o(rx_load), .quanta_o(rx_quanta),
    .status_valid(rx_status_valid), .status_filter(rx_status_filter)
  );

  pause_hold_timer #(.SLOT_TICKS(SLOT_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .load(rx_load), .quanta(rx_quanta), .hold(tx_hold)
  );
endmodule

// File: rtl/pause_ctrl_checker.sv
module pause_ctrl_checker (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr_en,
  input logic [31:0] reg_rdata,
  input logic        full_duplex,
  input logic        tx_enabled,
  input logic        pf_ready,
  input logic        pf_valid,
  input logic [7:0]  pf_byte,
  input logic        back_pressure,
  input logic        rx_status_valid,
  input logic        rx_status_filter
);
  // R2: reserved bits read zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[15:3] == 13'h0);

  // R3: write while busy leaves the control word unchanged
  a_r3_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_rdata[0]) |=> $stable(reg_rdata[31:1]));

  // R4: a stalled byte is held
  a_r4_stall_holds_byte: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_byte)));

  // R5: busy covers the whole frame in full duplex
  a_r5_busy_during_frame: assert property (@(posedge clk) disable iff (rst)
    (full_duplex && pf_valid) |-> reg_rdata[0]);

  // R6: busy mirrors back pressure in half duplex
  a_r6_busy_is_bp: assert property (@(posedge clk) disable iff (rst)
    (!full_duplex && back_pressure) |-> reg_rdata[0]);

  // R7: no back pressure after a disabled transmitter
  a_r7_no_bp_tx_off: assert property (@(posedge clk) disable iff (rst)
    !tx_enabled |=> !back_pressure);

  // R10: filter flag only with the status strobe
  a_r10_filter_with_strobe: assert property (@(posedge clk) disable iff (rst)
    rx_status_filter |-> rx_status_valid);
endmodule

bind mac_pause_ctrl pause_ctrl_checker chk_i (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rdata(reg_rdata),
  .full_duplex(full_duplex), .tx_enabled(tx_enabled), .pf_ready(pf_ready),
  .pf_valid(pf_valid), .pf_byte(pf_byte), .back_pressure(back_pressure),
  .rx_status_valid(rx_status_valid), .rx_status_filter(rx_status_filter)
);

// File: tb/mac_pause_ctrl_tb_top.sv
`timescale 1ns/1ps
module mac_pause_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        full_duplex = 1'b1, tx_enabled = 1'b1, promisc = 1'b0, pause_req = 1'b0;
  logic        pf_ready = 1'b1, pf_valid, pf_last, back_pressure;
  logic [7:0]  pf_byte;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_status_valid, rx_status_filter, tx_hold;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  mac_pause_ctrl dut_i (.*);

  typedef struct packed {
    logic        fd, en, pass, prom, bad_op;
    logic [15:0] quanta;
    logic        exp_filt;
    logic [23:0] exp_ticks;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd2, 1'b1, 24'd128},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1, 1'b0, 24'd64},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1, 1'b0, 24'd64},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd3, 1'b0, 24'd0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd2, 1'b0, 24'd0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd2, 1'b0, 24'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input int i, input logic [15:0] q, input logic bad);
    case (i)
      0: return 8'h01;  1: return 8'h80;  2: return 8'hC2;
      3: return 8'h00;  4: return 8'h00;  5: return 8'h01;
      6: return 8'h02;  7: return 8'h00;  8: return 8'h00;
      9: return 8'h00;  10: return 8'h00; 11: return 8'h0A;
      12: return 8'h88; 13: return 8'h08; 14: return 8'h00;
      15: return bad ? 8'h02 : 8'h01;
      16: return q[15:8];
      default: return q[7:0];
    endcase
  endfunction

  task automatic write_reg(input logic [31:0] v);
    @(negedge clk); reg_wr_en = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  // ends at the negedge after the final byte's edge
  task automatic send_frame(input logic [15:0] q, input logic bad);
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == 17);
      rx_byte = frame_byte(i, q, bad);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic measure_hold(output int n);
    n = 0;
    while (tx_hold && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 outputs", {28'h0, pf_valid, back_pressure, tx_hold, rx_status_valid}, 32'h0);

    // R2 layout
    write_reg(32'hABCD_FFFF);
    check("R2 layout", reg_rdata, 32'hABCD_0006);

    // table of receive vectors (R8 R9 R10)
    foreach (VECS[k]) begin
      full_duplex = VECS[k].fd;
      promisc     = VECS[k].prom;
      write_reg({16'h0, 13'h0, VECS[k].pass, VECS[k].en, 1'b0});
      send_frame(VECS[k].quanta, VECS[k].bad_op);
      check($sformatf("R10 strobe v%0d", k), {31'h0, rx_status_valid}, 32'h1);
      check($sformatf("R10 filter v%0d", k), {31'h0, rx_status_filter}, {31'h0, VECS[k].exp_filt});
      measure_hold(n);
      check($sformatf("R8/R9 hold ticks v%0d", k), n, {8'h0, VECS[k].exp_ticks});
    end
    promisc = 1'b0;

    // R4 R5 R3: full-duplex frame emission
    full_duplex = 1'b1; tx_enabled = 1'b1; pf_ready = 1'b0;
    write_reg(32'h1234_0000);
    @(negedge clk); pause_req = 1'b1;
    @(negedge clk); pause_req = 1'b0;
    check("R5 busy set", reg_rdata, 32'h1234_0001);
    check("R4 valid", {31'h0, pf_valid}, 32'h1);
    reg_wr_en = 1'b1; reg_wdata = 32'h5555_0006;
    @(negedge clk); reg_wr_en = 1'b0;
    check("R3 write ignored", reg_rdata, 32'h1234_0001);
    check("R4 stall byte0", {24'h0, pf_byte}, 32'h01);
    pf_ready = 1'b1;
    for (int i = 0; i < 18; i++) begin
      logic [7:0] eb;
      eb = frame_byte(i, 16'h1234, 1'b0);
      check($sformatf("R4 byte %0d", i), {22'h0, pf_valid, pf_last, pf_byte},
            {22'h0, 1'b1, (i == 17), eb});
      @(negedge clk);
    end
    check("R5 busy cleared", reg_rdata, 32'h1234_0000);
    check("R4 idle after", {31'h0, pf_valid}, 32'h0);

    // R7: transmitter off
    tx_enabled = 1'b0;
    @(negedge clk); pause_req = 1'b1;
    @(negedge clk); pause_req = 1'b0;
    check("R7 no frame", {30'h0, pf_valid, reg_rdata[0]}, 32'h0);

    // R6 R7: half duplex back pressure
    full_duplex = 1'b0;
    write_reg(32'h0000_0002);
    pause_req = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 no bp tx off", {31'h0, back_pressure}, 32'h0);
    tx_enabled = 1'b1;
    @(negedge clk);
    check("R6 bp on", {30'h0, back_pressure, reg_rdata[0]}, 32'h3);
    pause_req = 1'b0;
    @(negedge clk);
    check("R6 bp off", {30'h0, back_pressure, reg_rdata[0]}, 32'h0);
    write_reg(32'h0000_0000);
    pause_req = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 bp needs enable", {31'h0, back_pressure}, 32'h0);
    pause_req = 1'b0;

    // R11: reload and zero quanta
    full_duplex = 1'b1;
    write_reg(32'h0000_0002);
    send_frame(16'd3, 1'b0);
    repeat (50) @(negedge clk);
    send_frame(16'd1, 1'b0);
    measure_hold(n);
    check("R11 reload ticks", n, 32'd64);
    send_frame(16'd5, 1'b0);
    check("R11 running", {31'h0, tx_hold}, 32'h1);
    send_frame(16'd0, 1'b0);
    check("R11 zero ends", {31'h0, tx_hold}, 32'h0);

    // R1: reset clears a running state
    send_frame(16'd4, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 reset mid pause", {reg_rdata[30:0], tx_hold}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule